// File: doc/BRIEF.md
# Branch and Skip Next-Address Unit

This unit works out the program counter that follows a conditional flow-control opcode in a small 8-bit processor core. It takes the opcode already fetched, the program counter (which already points past that opcode), up to two inline bytes that follow the opcode, and the condition sources. The condition sources are the Q output latch, the carry flag, the accumulator, the interrupt-enable bit and four active-low external flag pins. It returns the next program counter and a flag that reports whether control flow was redirected.

Two opcode groups are handled. Opcodes with high nibble 3 are one-byte-operand branches. When taken, such a branch swaps in a new low byte and keeps the current page. Opcodes with high nibble C are either two-byte-operand branches or two-byte skips. Every non-taken case and every skip advances the program counter past the inline bytes it jumps over. Any other opcode passes the program counter through unchanged.

All outputs are registered, so a result appears on the clock edge after its inputs are presented. The core presents one opcode per cycle and uses the result one cycle later.

Top module: `bsn_next_pc`

## Requirements
- R1: A taken short branch (opcode 3x) produces `{pc_i[15:8], tgt_a_i}` and raises `redirect_o`.
- R2: A short branch that is not taken produces `pc_i + 1`, wrapping modulo 2^16, with `redirect_o` low.
- R3: A taken long branch produces `{tgt_a_i, tgt_b_i}` and raises `redirect_o`. The first inline byte is the high byte.
- R4: A long branch that is not taken produces `pc_i + 2`, wrapping modulo 2^16, with `redirect_o` low.
- R5: Short-branch conditions by opcode are as follows. 30 always. 31 when q_i=1. 32 when acc_i=0. 33 when df_i=1. 34..37 when EF1..EF4 is set. 39 when q_i=0. 3A when acc_i≠0. 3B when df_i=0. 3C..3F when EF1..EF4 is clear. EFk is set when bit k-1 of `ef_n_i` is 0.
- R6: Opcodes 38 and C8 never branch. 38 yields `pc_i + 1` and C8 yields `pc_i + 2`, both with `redirect_o` low.
- R7: Long-branch conditions by opcode are as follows. C0 always. C1 when q_i=1. C2 when acc_i=0. C3 when df_i=1. C9 when q_i=0. CA when acc_i≠0. CB when df_i=0.
- R8: Long skips are C5 (q_i=0), C6 (acc_i≠0), C7 (df_i=0), CC (ie_i=1), CD (q_i=1), CE (acc_i=0) and CF (df_i=1). When its condition holds, a long skip yields `pc_i + 2` with `redirect_o` high. Otherwise it yields `pc_i` with `redirect_o` low.
- R9: Opcode C4 yields `pc_i` with `redirect_o` low, whatever the flags.
- R10: Any opcode whose high nibble is neither 3 nor C yields `pc_i` with `redirect_o` low.
- R11: Outputs change on the clock edge after their inputs are presented. A synchronous reset clears `next_pc_o` and `redirect_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 8 | Fetched opcode |
| pc_i | input | 16 | Program counter, already past the opcode |
| tgt_a_i | input | 8 | First inline byte |
| tgt_b_i | input | 8 | Second inline byte |
| q_i | input | 1 | Output latch state |
| df_i | input | 1 | Carry flag |
| acc_i | input | 8 | Accumulator value |
| ie_i | input | 1 | Interrupt-enable bit |
| ef_n_i | input | 4 | External flags, active low, bit 0 is EF1 |
| next_pc_o | output | 16 | Registered next program counter |
| redirect_o | output | 1 | Registered taken/skip indication |

## Verification
The assertions compare each registered output with the inputs sampled one cycle earlier. They therefore assume the core holds a fresh, fully driven set of inputs in every cycle and treats every cycle as a new decode. The stimulus changes all inputs once per cycle at the falling edge. It walks every 3x and Cx opcode against all sixteen combinations of Q, carry, accumulator-zero and interrupt-enable, under several external-flag patterns. It places the program counter at page ends and at 0xFFFF/0xFFFE so that the one- and two-byte advances wrap. Random opcodes from outside both groups are also applied.

// File: rtl/bsn_pkg.sv
package bsn_pkg;

    localparam int BYTE_W = 8;
    localparam int EF_N   = 4;

    typedef enum logic [2:0] {
        K_NONE,
        K_SHORT,
        K_LONG,
        K_SKIP,
        K_NOP
    } flow_kind_e;

    typedef enum logic [2:0] {
        S_ALWAYS,
        S_Q,
        S_DZ,
        S_DF,
        S_EF,
        S_IE
    } cond_src_e;

    typedef struct packed {
        flow_kind_e kind;
        cond_src_e  src;
        logic [1:0] ef_idx;
        logic       invert;
    } flow_ctrl_t;

    typedef struct packed {
        logic q;
        logic df;
        logic dz;
        logic ie;
    } core_flags_t;

    function automatic cond_src_e low_src(input logic [1:0] sel);
        case (sel)
            2'd0:    return S_ALWAYS;
            2'd1:    return S_Q;
            2'd2:    return S_DZ;
            default: return S_DF;
        endcase
    endfunction

    function automatic flow_ctrl_t decode_op(input logic [7:0] op);
        flow_ctrl_t c;
        c.kind   = K_NONE;
        c.src    = S_ALWAYS;
        c.ef_idx = op[1:0];
        c.invert = 1'b0;
        if (op[7:4] == 4'h3) begin
            c.kind   = K_SHORT;
            c.src    = op[2] ? S_EF : low_src(op[1:0]);
            c.invert = op[3];
        end else if (op[7:4] == 4'hC) begin
            if (!op[2]) begin
                c.kind   = K_LONG;
                c.src    = low_src(op[1:0]);
                c.invert = op[3];
            end else if (op[1:0] == 2'd0) begin
                c.kind = op[3] ? K_SKIP : K_NOP;
                c.src  = S_IE;
            end else begin
                c.kind   = K_SKIP;
                c.src    = low_src(op[1:0]);
                c.invert = ~op[3];
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/bsn_decode.sv
module bsn_decode
    import bsn_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] opcode,
    output flow_ctrl_t      ctrl
);
    always_comb begin
        ctrl = decode_op(opcode[7:0]);
    end
endmodule

// File: rtl/bsn_cond.sv
module bsn_cond
    import bsn_pkg::*;
#(
    parameter int N_EF = EF_N
) (
    input  flow_ctrl_t      ctrl,
    input  core_flags_t     flags,
    input  logic [N_EF-1:0] ef_n,
    output logic            cond_true
);
    logic [N_EF-1:0] ef_set;
    logic            raw;

    for (genvar k = 0; k < N_EF; k++) begin : g_ef_inv
        assign ef_set[k] = ~ef_n[k];
    end

    always_comb begin
        case (ctrl.src)
            S_ALWAYS: raw = 1'b1;
            S_Q:      raw = flags.q;
            S_DZ:     raw = flags.dz;
            S_DF:     raw = flags.df;
            S_EF:     raw = ef_set[ctrl.ef_idx];
            S_IE:     raw = flags.ie;
            default:  raw = 1'b0;
        endcase
        cond_true = raw ^ ctrl.invert;
    end
endmodule

// File: rtl/bsn_addr.sv
module bsn_addr
    import bsn_pkg::*;
#(
    parameter int B_W = BYTE_W
) (
    input  flow_ctrl_t       ctrl,
    input  logic             cond_true,
    input  logic [2*B_W-1:0] pc,
    input  logic [B_W-1:0]   tgt_a,
    input  logic [B_W-1:0]   tgt_b,
    output logic [2*B_W-1:0] next_pc,
    output logic             taken
);
    localparam int PW = 2 * B_W;

    logic [PW-1:0] pc_p1, pc_p2;

    assign pc_p1 = pc + PW'(1);
    assign pc_p2 = pc + PW'(2);

    always_comb begin
        next_pc = pc;
        taken   = 1'b0;
        case (ctrl.kind)
            K_SHORT: begin
                taken   = cond_true;
                next_pc = cond_true ? {pc[PW-1:B_W], tgt_a} : pc_p1;
            end
            K_LONG: begin
                taken   = cond_true;
                next_pc = cond_true ? {tgt_a, tgt_b} : pc_p2;
            end
            K_SKIP: begin
                taken   = cond_true;
                next_pc = cond_true ? pc_p2 : pc;
            end
            default: begin
                next_pc = pc;
                taken   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bsn_next_pc.sv
module bsn_next_pc
    import bsn_pkg::*;
#(
    parameter int B_W  = BYTE_W,
    parameter int N_EF = EF_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       opcode_i,
    input  logic [2*B_W-1:0] pc_i,
    input  logic [B_W-1:0]   tgt_a_i,
    input  logic [B_W-1:0]   tgt_b_i,
    input  logic             q_i,
    input  logic             df_i,
    input  logic [B_W-1:0]   acc_i,
    input  logic             ie_i,
    input  logic [N_EF-1:0]  ef_n_i,
    output logic [2*B_W-1:0] next_pc_o,
    output logic             redirect_o
);
    localparam int PW = 2 * B_W;

    flow_ctrl_t    ctrl;
    core_flags_t   flags;
    logic          cond_true;
    logic [PW-1:0] nxt;
    logic          tkn;
    logic          primed;

    assign flags = '{q: q_i, df: df_i, dz: (acc_i == '0), ie: ie_i};

    bsn_decode #(.OP_W(8)) u_dec (
        .opcode (opcode_i),
        .ctrl   (ctrl)
    );

    bsn_cond #(.N_EF(N_EF)) u_cond (
        .ctrl      (ctrl),
        .flags     (flags),
        .ef_n      (ef_n_i),
        .cond_true (cond_true)
    );

    bsn_addr #(.B_W(B_W)) u_addr (
        .ctrl      (ctrl),
        .cond_true (cond_true),
        .pc        (pc_i),
        .tgt_a     (tgt_a_i),
        .tgt_b     (tgt_b_i),
        .next_pc   (nxt),
        .taken     (tkn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc_o  <= '0;
            redirect_o <= 1'b0;
            primed     <= 1'b0;
        end else begin
            next_pc_o  <= nxt;
            redirect_o <= tkn;
            primed     <= 1'b1;
        end
    end

    AST_SHORT_PAGE_KEPT: assert property (@(posedge clk) disable iff (rst)
        primed && $past(opcode_i[7:4] == 4'h3) && redirect_o
        |-> next_pc_o == {$past(pc_i[PW-1:B_W]), $past(tgt_a_i)}); // R1

    AST_SHORT_FALL_ADV: assert property (@(posedge clk) disable iff (rst)
        primed && $past(opcode_i[7:4] == 4'h3) && !redirect_o
        |-> next_pc_o == $past(pc_i) + PW'(1)); // R2

    AST_LONG_FALL_ADV: assert property (@(posedge clk) disable iff (rst)
        primed && $past(opcode_i[7:4] == 4'hC && !opcode_i[2]) && !redirect_o
        |-> next_pc_o == $past(pc_i) + PW'(2)); // R4

    AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
        primed && $past(opcode_i == 8'h38 || opcode_i == 8'hC8)
        |-> !redirect_o); // R6

    AST_SKIP_RESULT: assert property (@(posedge clk) disable iff (rst)
        primed && $past(opcode_i[7:4] == 4'hC && opcode_i[2])
        |-> next_pc_o == (redirect_o ? $past(pc_i) + PW'(2) : $past(pc_i))); // R8

    AST_NOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        primed && $past(opcode_i == 8'hC4)
        |-> !redirect_o && next_pc_o == $past(pc_i)); // R9

    AST_OTHER_PASS: assert property (@(posedge clk) disable iff (rst)
        primed && $past(opcode_i[7:4] != 4'h3 && opcode_i[7:4] != 4'hC)
        |-> !redirect_o && next_pc_o == $past(pc_i)); // R10

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) && primed == 1'b0 |-> next_pc_o == '0 && !redirect_o); // R11
endmodule

// File: tb/tb_bsn_next_pc.sv
module tb_bsn_next_pc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  opcode_i = 8'h00;
    logic [15:0] pc_i = 16'h0;
    logic [7:0]  tgt_a_i = 8'h0, tgt_b_i = 8'h0;
    logic        q_i = 1'b0, df_i = 1'b0, ie_i = 1'b0;
    logic [7:0]  acc_i = 8'h0;
    logic [3:0]  ef_n_i = 4'hF;
    logic [15:0] next_pc_o;
    logic        redirect_o;

    int n_chk = 0;
    int n_bad = 0;
    int q_pc[$];
    int q_tk[$];
    string q_tag[$];

    always #10 clk = ~clk;

    bsn_next_pc dut (
        .clk(clk), .rst(rst), .opcode_i(opcode_i), .pc_i(pc_i),
        .tgt_a_i(tgt_a_i), .tgt_b_i(tgt_b_i), .q_i(q_i), .df_i(df_i),
        .acc_i(acc_i), .ie_i(ie_i), .ef_n_i(ef_n_i),
        .next_pc_o(next_pc_o), .redirect_o(redirect_o)
    );

    task automatic check(input string tag, input int got_pc, input int got_tk,
                         input int exp_pc, input int exp_tk);
        n_chk++;
        if (got_pc != exp_pc || got_tk != exp_tk) begin
            n_bad++;
            $display("FAIL %s: got pc=%04h taken=%0d, expected pc=%04h taken=%0d",
                     tag, got_pc, got_tk, exp_pc, exp_tk);
        end
    endtask

    // Behavioural reference, written per opcode from the requirements.
    task automatic model(input int op, input int pc, input int a, input int b,
                         input bit q, input bit df, input int acc, input bit ie,
                         input bit [3:0] efn, output int npc, output int tk,
                         output string tag);
        bit dz = (acc == 0);
        bit [3:0] ef = ~efn;
        bit c = 0;
        npc = pc; tk = 0; tag = "R10";
        if (op >= 'h30 && op <= 'h3F) begin
            case (op)
                'h30: c = 1;       'h31: c = q;        'h32: c = dz;      'h33: c = df;
                'h34: c = ef[0];   'h35: c = ef[1];    'h36: c = ef[2];   'h37: c = ef[3];
                'h38: c = 0;       'h39: c = !q;       'h3A: c = !dz;     'h3B: c = !df;
                'h3C: c = !ef[0];  'h3D: c = !ef[1];   'h3E: c = !ef[2];  'h3F: c = !ef[3];
                default: c = 0;
            endcase
            if (c) begin npc = (pc & 'hFF00) | a; tk = 1; tag = "R1,R5"; end
            else begin npc = (pc + 1) & 'hFFFF; tag = (op == 'h38) ? "R6" : "R2,R5"; end
        end else if (op inside {'hC0, 'hC1, 'hC2, 'hC3, 'hC8, 'hC9, 'hCA, 'hCB}) begin
            case (op)
                'hC0: c = 1;  'hC1: c = q;   'hC2: c = dz;   'hC3: c = df;
                'hC9: c = !q; 'hCA: c = !dz; 'hCB: c = !df;  default: c = 0;
            endcase
            if (c) begin npc = (a << 8) | b; tk = 1; tag = "R3,R7"; end
            else begin npc = (pc + 2) & 'hFFFF; tag = (op == 'hC8) ? "R6" : "R4,R7"; end
        end else if (op == 'hC4) begin
            tag = "R9";
        end else if (op >= 'hC5 && op <= 'hCF) begin
            case (op)
                'hC5: c = !q; 'hC6: c = !dz; 'hC7: c = !df; 'hCC: c = ie;
                'hCD: c = q;  'hCE: c = dz;  'hCF: c = df;  default: c = 0;
            endcase
            tag = "R8";
            if (c) begin npc = (pc + 2) & 'hFFFF; tk = 1; end
        end
    endtask

    task automatic apply(input int op, input int pc, input int a, input int b,
                         input bit q, input bit df, input int acc, input bit ie,
                         input bit [3:0] efn);
        int npc, tk;
        string tag;
        @(negedge clk);
        if (q_pc.size() > 0)
            check(q_tag.pop_front(), next_pc_o, redirect_o, q_pc.pop_front(), q_tk.pop_front());
        opcode_i = op[7:0]; pc_i = pc[15:0]; tgt_a_i = a[7:0]; tgt_b_i = b[7:0];
        q_i = q; df_i = df; acc_i = acc[7:0]; ie_i = ie; ef_n_i = efn;
        model(op, pc, a, b, q, df, acc, ie, efn, npc, tk, tag);
        q_pc.push_back(npc); q_tk.push_back(tk); q_tag.push_back(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        bit [3:0] ef_pats [4] = '{4'hF, 4'h0, 4'hA, 4'h5};
        opcode_i = 8'h30; pc_i = 16'h1234; tgt_a_i = 8'h55;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", next_pc_o, redirect_o, 0, 0);
        rst = 1'b0;
        for (int e = 0; e < 4; e++) begin
            for (int grp = 0; grp < 2; grp++) begin
                for (int lo = 0; lo < 16; lo++) begin
                    for (int f = 0; f < 16; f++) begin
                        int op = (grp == 0 ? 'h30 : 'hC0) + lo;
                        int pc = (f == 3) ? 'hFFFF : (f == 7) ? 'hFFFE : (f == 11) ? 'h12FF
                                 : ('h0100 * (lo + 1) + f * 17 + e);
                        apply(op, pc, 'h5A ^ f, 'hC3 + lo, f[0], f[1],
                              f[2] ? 0 : (f + 1), f[3], ef_pats[e]);
                    end
                end
            end
        end
        for (int k = 0; k < 600; k++) begin
            int op = $urandom_range(0, 255);
            int pc = (k % 50 == 0) ? 'hFFFF : $urandom_range(0, 65535);
            apply(op, pc, $urandom_range(0, 255), $urandom_range(0, 255),
                  $urandom_range(0, 1), $urandom_range(0, 1),
                  (k % 3 == 0) ? 0 : $urandom_range(0, 255),
                  $urandom_range(0, 1), 4'($urandom_range(0, 15)));
        end
        apply('h00, 0, 0, 0, 0, 0, 0, 0, 4'hF);
        @(negedge clk);
        while (q_pc.size() > 0)
            check(q_tag.pop_front(), next_pc_o, redirect_o, q_pc.pop_front(), q_tk.pop_front());
        rst = 1'b1;
        @(negedge clk);
        check("R11", next_pc_o, redirect_o, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule